// File: doc/BRIEF.md
# Performance Counter Box with Freeze Control

This block is a small performance-monitoring unit. It has four generic event counters, and each counter has its own control word. Each control word holds an enable bit and an event index, which picks one line from a vector of event pulses. A counter adds one on every clock in which it is enabled, its chosen event line is high, and the box is not frozen. A box-wide command register freezes the generic counters and issues one-shot clear strobes. The freeze can come from an external freeze input or from a manual bit, and either source acts only while the freeze-enable bit is set. One strobe clears the counter values and a separate strobe clears the control words.

Next to the box sit two fixed residency counters. Each one adds one on every cycle its residency input is high. Box freeze and box clears never touch them. All registers are reached through one flat register port. Writes take one clock. Reads are combinational from the address. A 32-bit filter register is stored and read back but has no effect on counting.

Top module: `perf_mon_box`

## Requirements
- R1: A generic counter adds one on a clock edge when its control bit 22 is 1, its event index (control bits 7:0) is below the number of event lines, that event line is high and the box is not frozen. An index at or above the line count never counts, and other event lines have no effect.
- R2: Each control word reads back only bit 22 and bits 7:0, with all other bits 0. The filter register at 0xC34 stores and returns the low 32 bits written.
- R3: With box bit 16 (freeze-enable) at 1, a high external freeze input stops all generic counters. With bit 16 at 0, the freeze input has no effect.
- R4: Box bit 8 (manual freeze) stops the generic counters only while bit 16 is also 1.
- R5: A box write with bit 1 set clears every generic counter on that edge. This clear wins over a same-cycle event and leaves the control words unchanged.
- R6: A box write with bit 0 set clears every control word on that edge and leaves the counter values unchanged.
- R7: The box register at 0xC24 always reads 0. A box write with reserved bit 17 set is ignored entirely.
- R8: Each fixed residency counter (0x3FC, 0x3FD) adds one per cycle its residency input is high. Freeze, both clear strobes and writes to its address do not affect it.
- R9: Control words sit at 0xC30 to 0xC33 and counters 0 to 3 at 0xC36 to 0xC39. A counter can be loaded by a write, is 64 bits wide and wraps to 0. Any unmapped address reads 0.
- R10: After reset every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register address for read and write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data for `addr`, combinational |
| events | input | NUM_EVT (8) | Event pulse lines from monitored logic |
| freeze_in | input | 1 | External freeze request |
| resid_in | input | NUM_FIX (2) | Residency condition per fixed counter |

## Verification
The assertions assume that a write to a control word never arrives in the same cycle as a control-clear strobe, since the two use different addresses on the single write port. They also assume that software keeps bit 17 at 0 whenever it means a box command to act. The bench drives one access per cycle, so those cases cannot arise. It sets bit 17 only in the deliberate check that such a write is ignored. The counter-hold property covers only cycles without a write, because a load into a frozen counter is legal. The bench therefore loads counters only while the box is not frozen, and it changes inputs on the falling edge so that each event window spans a known number of rising edges.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int ADDR_W       = 12;
    localparam int DATA_W       = 64;
    localparam int EVSEL_W      = 8;
    localparam int FILT_W       = 32;

    localparam int CTL_EN_BIT   = 22;
    localparam int BOX_FRZEN    = 16;
    localparam int BOX_RSV      = 17;
    localparam int BOX_FRZ      = 8;
    localparam int BOX_CLRCTR   = 1;
    localparam int BOX_CLRCTL   = 0;

    localparam logic [ADDR_W-1:0] BOX_ADDR  = 12'hC24;
    localparam logic [ADDR_W-1:0] CTL_BASE  = 12'hC30;
    localparam logic [ADDR_W-1:0] FILT_ADDR = 12'hC34;
    localparam logic [ADDR_W-1:0] CTR_BASE  = 12'hC36;
    localparam logic [ADDR_W-1:0] FIX_BASE  = 12'h3FC;

    typedef struct packed {
        logic               en;
        logic [EVSEL_W-1:0] sel;
    } ctl_t;

    typedef struct packed {
        logic valid;
        logic frz_en;
        logic frz;
        logic clr_ctrs;
        logic clr_ctls;
    } box_cmd_t;

    function automatic box_cmd_t decode_box(input logic hit, input logic [DATA_W-1:0] d);
        box_cmd_t c;
        c.valid    = hit && !d[BOX_RSV];
        c.frz_en   = d[BOX_FRZEN];
        c.frz      = d[BOX_FRZ];
        c.clr_ctrs = c.valid && d[BOX_CLRCTR];
        c.clr_ctls = c.valid && d[BOX_CLRCTL];
        return c;
    endfunction

    function automatic ctl_t word_to_ctl(input logic [DATA_W-1:0] d);
        ctl_t c;
        c.en  = d[CTL_EN_BIT];
        c.sel = d[EVSEL_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_to_word(input ctl_t c);
        logic [DATA_W-1:0] w;
        w                = '0;
        w[CTL_EN_BIT]    = c.en;
        w[EVSEL_W-1:0]   = c.sel;
        return w;
    endfunction

endpackage

// File: rtl/pmu_gen_ctr.sv
module pmu_gen_ctr #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr)  q <= '0;
        else if (ld)     q <= ld_val;
        else if (inc)    q <= q + W'(1);
    end
endmodule

// File: rtl/pmu_ctl_bank.sv
module pmu_ctl_bank
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic [NUM_CTR-1:0]      wr_sel,
    input  logic [DATA_W-1:0]       wr_data,
    output ctl_t [NUM_CTR-1:0]      ctl_q
);
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst || clr)     ctl_q[g] <= '0;
            else if (wr_sel[g]) ctl_q[g] <= word_to_ctl(wr_data);
        end
    end
endmodule

// File: rtl/perf_mon_box.sv
module perf_mon_box
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 64,
    parameter int NUM_EVT = 8,
    parameter int NUM_FIX = 2,
    parameter int FIX_W   = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_EVT-1:0]   events,
    input  logic                 freeze_in,
    input  logic [NUM_FIX-1:0]   resid_in
);
    localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam logic [EVSEL_W:0] NUM_EVT_L = (EVSEL_W+1)'(NUM_EVT);

    box_cmd_t                         cmd;
    logic                             frz_en_q, frz_q, frozen;
    logic [FILT_W-1:0]                filt_q;
    logic [NUM_CTR-1:0]               ctl_wr, ctr_ld, ctr_inc;
    ctl_t [NUM_CTR-1:0]               ctl_q;
    logic [NUM_CTR-1:0][CTR_W-1:0]    ctr_q;
    logic [NUM_FIX-1:0][FIX_W-1:0]    fix_q;
    logic                             unused_wdata;

    assign unused_wdata = ^wr_data;

    // box command decode and stored freeze state
    assign cmd = decode_box(wr_en && (addr == BOX_ADDR), wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            frz_en_q <= 1'b0;
            frz_q    <= 1'b0;
        end else if (cmd.valid) begin
            frz_en_q <= cmd.frz_en;
            frz_q    <= cmd.frz;
        end
    end

    assign frozen = frz_en_q && (freeze_in || frz_q);

    always_ff @(posedge clk) begin
        if (rst)                                 filt_q <= '0;
        else if (wr_en && (addr == FILT_ADDR))   filt_q <= wr_data[FILT_W-1:0];
    end

    pmu_ctl_bank #(.NUM_CTR(NUM_CTR)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .clr     (cmd.clr_ctls),
        .wr_sel  (ctl_wr),
        .wr_data (wr_data),
        .ctl_q   (ctl_q)
    );

    // generic counters
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        logic in_range, hit;
        assign ctl_wr[g]  = wr_en && (addr == CTL_BASE + ADDR_W'(g));
        assign ctr_ld[g]  = wr_en && (addr == CTR_BASE + ADDR_W'(g));
        assign in_range   = {1'b0, ctl_q[g].sel} < NUM_EVT_L;
        assign hit        = in_range && events[ctl_q[g].sel[IDX_W-1:0]];
        assign ctr_inc[g] = ctl_q[g].en && hit && !frozen;

        pmu_gen_ctr #(.W(CTR_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .clr    (cmd.clr_ctrs),
            .ld     (ctr_ld[g]),
            .ld_val (wr_data[CTR_W-1:0]),
            .inc    (ctr_inc[g]),
            .q      (ctr_q[g])
        );
    end

    // fixed residency counters: outside freeze and clear
    for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
        pmu_gen_ctr #(.W(FIX_W)) u_fix (
            .clk    (clk),
            .rst    (rst),
            .clr    (1'b0),
            .ld     (1'b0),
            .ld_val ('0),
            .inc    (resid_in[f]),
            .q      (fix_q[f])
        );
    end

    // read mux
    always_comb begin
        rd_data = '0;
        if (addr == FILT_ADDR) rd_data = DATA_W'(filt_q);
        for (int i = 0; i < NUM_CTR; i++) begin
            if (addr == CTL_BASE + ADDR_W'(i)) rd_data = ctl_to_word(ctl_q[i]);
            if (addr == CTR_BASE + ADDR_W'(i)) rd_data = DATA_W'(ctr_q[i]);
        end
        for (int i = 0; i < NUM_FIX; i++) begin
            if (addr == FIX_BASE + ADDR_W'(i)) rd_data = DATA_W'(fix_q[i]);
        end
    end

endmodule

// File: rtl/pmu_box_chk.sv
module pmu_box_chk
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 64,
    parameter int NUM_FIX = 2,
    parameter int FIX_W   = 64,
    parameter int CTL_W   = $bits(ctl_t)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [DATA_W-1:0]           wr_data,
    input logic [DATA_W-1:0]           rd_data,
    input logic [NUM_FIX-1:0]          resid_in,
    input logic                        frozen,
    input logic [NUM_CTR*CTR_W-1:0]    ctr_q,
    input logic [NUM_CTR*CTL_W-1:0]    ctl_q,
    input logic [NUM_FIX*FIX_W-1:0]    fix_q
);
    logic box_ok;
    logic unused_chk;
    assign box_ok     = wr_en && (addr == BOX_ADDR) && !wr_data[BOX_RSV];
    assign unused_chk = ^wr_data;

    // R3 / R4: a frozen box holds every generic counter when nothing is written
    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        (frozen && !wr_en) |=> $stable(ctr_q));

    // R5: counter clear strobe
    a_r5_clear_counters: assert property (@(posedge clk) disable iff (rst)
        (box_ok && wr_data[BOX_CLRCTR]) |=> (ctr_q == '0));

    // R6: control clear strobe
    a_r6_clear_controls: assert property (@(posedge clk) disable iff (rst)
        (box_ok && wr_data[BOX_CLRCTL]) |=> (ctl_q == '0));

    // R7: box register reads zero
    a_r7_box_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (addr == BOX_ADDR) |-> (rd_data == '0));

    for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix_chk
        // R8: residency counting unaffected by box state
        a_r8_fix_count: assert property (@(posedge clk) disable iff (rst)
            resid_in[f] |=> (fix_q[f*FIX_W +: FIX_W] == $past(fix_q[f*FIX_W +: FIX_W]) + FIX_W'(1)));
        a_r8_fix_hold: assert property (@(posedge clk) disable iff (rst)
            !resid_in[f] |=> $stable(fix_q[f*FIX_W +: FIX_W]));
    end
endmodule

bind perf_mon_box pmu_box_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .NUM_FIX (NUM_FIX),
    .FIX_W   (FIX_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .resid_in (resid_in),
    .frozen   (frozen),
    .ctr_q    (ctr_q),
    .ctl_q    (ctl_q),
    .fix_q    (fix_q)
);

// File: tb/perf_mon_box_tb.sv
`timescale 1ns/1ps
module perf_mon_box_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic [7:0]  events = '0;
    logic        freeze_in = 1'b0;
    logic [1:0]  resid_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [11:0] A_BOX  = 12'hC24;
    localparam logic [11:0] A_CTL  = 12'hC30;
    localparam logic [11:0] A_FILT = 12'hC34;
    localparam logic [11:0] A_CTR  = 12'hC36;
    localparam logic [11:0] A_FIX  = 12'h3FC;
    localparam logic [63:0] EN     = 64'h40_0000;

    always #4 clk = ~clk;

    perf_mon_box u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .events(events), .freeze_in(freeze_in), .resid_in(resid_in)
    );

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic chk(input logic [11:0] a, input logic [63:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] ev, input int k);
        @(negedge clk);
        events = ev;
        repeat (k) @(negedge clk);
        events = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk(A_BOX, 0, "R10");
        chk(A_FILT, 0, "R10");
        for (int i = 0; i < 4; i++) begin
            chk(A_CTL + 12'(i), 0, "R10");
            chk(A_CTR + 12'(i), 0, "R10");
        end
        chk(A_FIX, 0, "R10");
        chk(A_FIX + 12'd1, 0, "R10");

        // R1: sweep every counter over every in-range and two out-of-range indices
        for (int c = 0; c < 4; c++) begin
            for (int e = 0; e < 10; e++) begin
                int k;
                logic [63:0] exp;
                k = e + 2;
                wr(A_BOX, 64'h3);
                wr(A_CTL + 12'(c), EN | 64'(e));
                if (e < 8) pulse(~(8'd1 << e), 2);
                pulse(8'hFF, k);
                exp = (e < 8) ? 64'(k) : 64'd0;
                chk(A_CTR + 12'(c), exp, "R1");
                chk(A_CTR + 12'((c + 1) % 4), 0, "R1");
            end
        end

        // R3: external freeze
        wr(A_BOX, 64'h3);
        wr(A_CTL, EN);
        freeze_in = 1'b1;
        pulse(8'h01, 5);
        chk(A_CTR, 5, "R3");
        wr(A_BOX, 64'h1_0000);
        pulse(8'h01, 4);
        chk(A_CTR, 5, "R3");
        freeze_in = 1'b0;
        pulse(8'h01, 3);
        chk(A_CTR, 8, "R3");

        // R4: manual freeze needs freeze-enable
        wr(A_BOX, 64'h100);
        pulse(8'h01, 2);
        chk(A_CTR, 10, "R4");
        wr(A_BOX, 64'h1_0100);
        pulse(8'h01, 3);
        chk(A_CTR, 10, "R4");
        wr(A_BOX, 64'h0);
        pulse(8'h01, 1);
        chk(A_CTR, 11, "R4");

        // R7: box reads zero; bit 17 write ignored
        chk(A_BOX, 0, "R7");
        wr(A_BOX, 64'h3_0100);
        pulse(8'h01, 2);
        chk(A_CTR, 13, "R7");
        wr(A_BOX, 64'h2_0003);
        chk(A_CTR, 13, "R7");
        chk(A_CTL, EN, "R7");

        // R5: counter clear wins over same-cycle event, keeps controls
        @(negedge clk);
        events = 8'h01; wr_en = 1'b1; addr = A_BOX; wr_data = 64'h2;
        @(negedge clk);
        events = '0; wr_en = 1'b0; wr_data = '0;
        chk(A_CTR, 0, "R5");
        chk(A_CTL, EN, "R5");

        // R6: control clear keeps counter values
        wr(A_CTR, 64'd7);
        wr(A_BOX, 64'h1);
        chk(A_CTL, 0, "R6");
        chk(A_CTR, 7, "R6");
        pulse(8'h01, 2);
        chk(A_CTR, 7, "R6");

        // R9: load and 64-bit wrap, unmapped reads
        wr(A_CTL + 12'd1, EN | 64'd3);
        wr(A_CTR + 12'd1, 64'hFFFF_FFFF_FFFF_FFFE);
        pulse(8'h08, 3);
        chk(A_CTR + 12'd1, 1, "R9");
        wr(12'hC35, 64'hFFFF);
        chk(12'hC35, 0, "R9");
        chk(12'hC3A, 0, "R9");

        // R2: control and filter read-back widths
        wr(A_CTL + 12'd2, '1);
        chk(A_CTL + 12'd2, 64'h40_00FF, "R2");
        wr(A_FILT, '1);
        chk(A_FILT, 64'hFFFF_FFFF, "R2");

        // R8: residency counters ignore freeze, clears and writes
        @(negedge clk);
        freeze_in = 1'b1;
        resid_in = 2'b01;
        wr(A_BOX, 64'h1_0103);
        resid_in = 2'b00;
        wr(A_FIX, 64'd100);
        chk(A_FIX, 2, "R8");
        chk(A_FIX + 12'd1, 0, "R8");
        @(negedge clk);
        resid_in = 2'b11;
        repeat (5) @(negedge clk);
        resid_in = 2'b00;
        chk(A_FIX, 7, "R8");
        chk(A_FIX + 12'd1, 5, "R8");
        freeze_in = 1'b0;
        wr(A_BOX, 64'h0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule